// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block watches a shared local bus and tracks atomic read-modify-write sequences. It sees every transaction that goes to the bus slaves. Each master that can do atomics gets one reservation record, which holds a valid flag and a word address. Load-reserve, store and conditional-store traffic updates these records. When a conditional store appears, the block decides in the same cycle whether that store may write. If it may not, the block asserts a write-inhibit so that the memory keeps its old contents. That verdict is the only way a lost reservation is ever reported: there is no separate signal for the loss.

Other agents can also write on the bus, for example DMA engines. They use master IDs at or above `NUM_MASTERS`. They cannot hold a reservation, but their stores still break reservations held by the masters. The snoop port accepts at most one transaction per clock. The verdict outputs are combinational from that port.

Top module: `resv_monitor`

## Requirements
- R1: A synchronous active-high reset clears every reservation, so a conditional store issued after reset fails.
- R2: A load-reserve (op code 1) by master m sets m's flag and records the word address (address bits above bit 1). A later conditional store (op code 3) by m to that word passes.
- R3: A second load-reserve by the same master replaces the earlier address. A conditional store to the old word then fails.
- R4: A conditional store by a master clears that master's own flag whether it passes or fails, so an immediate repeat fails.
- R5: A plain store (op code 2) by the owning master, even to its own reserved word, leaves its reservation intact.
- R6: A plain store by any other master to a reserved word clears that reservation. A store to a different word does not clear it.
- R7: A conditional store passes only if the issuing master's flag is set and the store's word address equals the recorded one. Address bits 1:0 take no part in the comparison.
- R8: `sc_pass` and `sc_inhibit` respond in the same cycle as the snooped conditional store, and exactly one of them is high for it. Both are low for every other cycle.
- R9: A passing conditional store also clears every other master's reservation on the same word. A failing one disturbs no other reservation.
- R10: Agents with ID ≥ `NUM_MASTERS` never hold a reservation. Their load-reserve has no effect, their conditional store always fails, and their stores clear matching reservations.
- R11: A plain read (op code 0), and any cycle with `snp_valid` low, leaves all reservations unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| snp_valid | input | 1 | A transaction is present on the snoop port this cycle |
| snp_master | input | ID_W ($clog2(NUM_MASTERS)+1) | Requesting agent ID |
| snp_addr | input | ADDR_W | Byte address of the transaction |
| snp_op | input | 2 | 0 read, 1 load-reserve, 2 store, 3 conditional store |
| sc_pass | output | 1 | The conditional store this cycle may write |
| sc_inhibit | output | 1 | The conditional store this cycle must not write |

## Verification
The bench uses the default build: four reserving masters, a 3-bit ID and a 32-bit address. The spare ID values 4 to 7 let the bench play a non-reserving agent, so the rules for foreign stores and refused reservations in R10 can be exercised. Four slots also leave room to put two masters' reservations on the same word while a third master is active elsewhere. That makes the clear-on-pass and no-clear-on-fail cases of R9 observable through later conditional stores.

// File: rtl/resv_pkg.sv
`timescale 1ns/1ps
package resv_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_LDRSV = 2'd1,
    OP_STORE = 2'd2,
    OP_STCND = 2'd3
  } resv_op_e;
endpackage

// File: rtl/resv_decode.sv
`timescale 1ns/1ps
module resv_decode #(
  parameter int NUM_MASTERS = 4,
  parameter int ID_W        = 3
) (
  input  logic                   valid,
  input  logic [ID_W-1:0]        master,
  input  resv_pkg::resv_op_e     op,
  output logic                   is_ldrsv,
  output logic                   is_store,
  output logic                   is_stcnd,
  output logic [NUM_MASTERS-1:0] own_mask
);
  import resv_pkg::*;

  assign is_ldrsv = valid && (op == OP_LDRSV);
  assign is_store = valid && (op == OP_STORE);
  assign is_stcnd = valid && (op == OP_STCND);

  // One-hot select of the issuing slot; all zero for non-reserving agents.
  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_own
    assign own_mask[g] = (master == ID_W'(g));
  end
endmodule

// File: rtl/resv_slot.sv
`timescale 1ns/1ps
module resv_slot #(
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [WORD_W-1:0] word_in,
  output logic              flag,
  output logic              hit
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      word_q <= '0;
    end else if (set_en) begin
      flag   <= 1'b1;
      word_q <= word_in;
    end else if (clr_en) begin
      flag   <= 1'b0;
    end
  end

  assign hit = flag && (word_q == word_in);
endmodule

// File: rtl/resv_monitor.sv
`timescale 1ns/1ps
module resv_monitor #(
  parameter int NUM_MASTERS = 4,
  parameter int ADDR_W      = 32,
  localparam int ID_W       = $clog2(NUM_MASTERS) + 1,
  localparam int WORD_W     = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid,
  input  logic [ID_W-1:0]   snp_master,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [1:0]        snp_op,
  output logic              sc_pass,
  output logic              sc_inhibit
);
  import resv_pkg::*;

  function automatic logic [WORD_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:2];
  endfunction

  function automatic logic verdict(input logic cond,
                                   input logic [NUM_MASTERS-1:0] own,
                                   input logic [NUM_MASTERS-1:0] hits);
    return cond && (|(own & hits));
  endfunction

  // Named internal events for the checker.
  logic                   ev_ldrsv, ev_store, ev_stcnd;
  logic [NUM_MASTERS-1:0] own_mask;
  logic [NUM_MASTERS-1:0] hit_vec;
  logic [NUM_MASTERS-1:0] rsv_flag;
  logic [NUM_MASTERS-1:0] set_vec;
  logic [NUM_MASTERS-1:0] clr_vec;
  logic [WORD_W-1:0]      snp_word;

  assign snp_word = word_of(snp_addr);

  resv_decode #(.NUM_MASTERS(NUM_MASTERS), .ID_W(ID_W)) u_dec (
    .valid    (snp_valid),
    .master   (snp_master),
    .op       (resv_op_e'(snp_op)),
    .is_ldrsv (ev_ldrsv),
    .is_store (ev_store),
    .is_stcnd (ev_stcnd),
    .own_mask (own_mask)
  );

  assign sc_pass    = verdict(ev_stcnd, own_mask, hit_vec);
  assign sc_inhibit = ev_stcnd && !sc_pass;

  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_slot
    assign set_vec[g] = ev_ldrsv && own_mask[g];
    assign clr_vec[g] = (own_mask[g] && ev_stcnd) ||
                        (!own_mask[g] && hit_vec[g] && (ev_store || sc_pass));
    resv_slot #(.WORD_W(WORD_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .set_en  (set_vec[g]),
      .clr_en  (clr_vec[g]),
      .word_in (snp_word),
      .flag    (rsv_flag[g]),
      .hit     (hit_vec[g])
    );
  end
endmodule

// File: rtl/resv_monitor_chk.sv
`timescale 1ns/1ps
module resv_monitor_chk #(
  parameter int NUM_MASTERS = 4,
  parameter int ID_W        = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   snp_valid,
  input logic [ID_W-1:0]        snp_master,
  input logic [1:0]             snp_op,
  input logic                   sc_pass,
  input logic                   sc_inhibit,
  input logic [NUM_MASTERS-1:0] rsv_flag
);
  localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_MASTERS);

  logic [NUM_MASTERS-1:0] sel;
  logic                   known;
  assign sel   = NUM_MASTERS'(1) << snp_master;
  assign known = snp_master < LIMIT;

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> rsv_flag == '0);

  a_r2_ldrsv_sets: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_op == 2'd1 && known) |=> |(rsv_flag & $past(sel)));

  a_r4_stcnd_clears_own: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_op == 2'd3 && known) |=> !(|(rsv_flag & $past(sel))));

  a_r7_pass_needs_flag: assert property (@(posedge clk) disable iff (rst)
    sc_pass |-> (known && |(rsv_flag & sel)));

  a_r8_verdict_only_on_stcnd: assert property (@(posedge clk) disable iff (rst)
    (sc_pass || sc_inhibit) |-> (snp_valid && snp_op == 2'd3 && !(sc_pass && sc_inhibit)));

  a_r10_agent_no_reserve: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && !known) |=> (rsv_flag & ~$past(rsv_flag)) == '0);

  a_r11_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!snp_valid || snp_op == 2'd0) |=> $stable(rsv_flag));
endmodule

bind resv_monitor resv_monitor_chk #(.NUM_MASTERS(NUM_MASTERS), .ID_W(ID_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .snp_valid  (snp_valid),
  .snp_master (snp_master),
  .snp_op     (snp_op),
  .sc_pass    (sc_pass),
  .sc_inhibit (sc_inhibit),
  .rsv_flag   (rsv_flag)
);

// File: tb/resv_monitor_tb.sv
`timescale 1ns/1ps
module resv_monitor_tb;
  localparam int NM = 4;
  localparam int AW = 32;
  localparam int IW = 3;
  localparam int NV = 34;

  // vector: {master[3], addr[32], op[2], expected pass[1]}
  // ops: 0 read, 1 load-reserve, 2 store, 3 conditional store
  localparam logic [37:0] VEC [NV] = '{
    {3'd0, 32'h100, 2'd3, 1'b0},  // R1: nothing reserved after reset
    {3'd0, 32'h100, 2'd1, 1'b0},  // R2
    {3'd0, 32'h103, 2'd3, 1'b1},  // R2 R7: low bits ignored
    {3'd0, 32'h100, 2'd3, 1'b0},  // R4: repeat fails
    {3'd1, 32'h200, 2'd1, 1'b0},  // R3
    {3'd1, 32'h300, 2'd1, 1'b0},  // R3 replace
    {3'd1, 32'h200, 2'd3, 1'b0},  // R3 old word fails
    {3'd1, 32'h300, 2'd1, 1'b0},  // R5
    {3'd1, 32'h300, 2'd2, 1'b0},  // R5 own store
    {3'd1, 32'h300, 2'd3, 1'b1},  // R5 still held
    {3'd2, 32'h400, 2'd1, 1'b0},  // R6
    {3'd3, 32'h404, 2'd2, 1'b0},  // R6 other word
    {3'd2, 32'h400, 2'd3, 1'b1},  // R6 kept
    {3'd2, 32'h400, 2'd1, 1'b0},  // R6
    {3'd3, 32'h402, 2'd2, 1'b0},  // R6 same word
    {3'd2, 32'h400, 2'd3, 1'b0},  // R6 lost
    {3'd0, 32'h500, 2'd1, 1'b0},  // R9
    {3'd1, 32'h500, 2'd1, 1'b0},  // R9
    {3'd0, 32'h500, 2'd3, 1'b1},  // R9 pass
    {3'd1, 32'h500, 2'd3, 1'b0},  // R9 cleared by pass
    {3'd0, 32'h600, 2'd1, 1'b0},  // R9
    {3'd1, 32'h600, 2'd3, 1'b0},  // R9 failing cond store
    {3'd0, 32'h600, 2'd3, 1'b1},  // R9 untouched
    {3'd2, 32'h700, 2'd1, 1'b0},  // R10
    {3'd5, 32'h700, 2'd1, 1'b0},  // R10 agent reserve
    {3'd5, 32'h700, 2'd3, 1'b0},  // R10 agent cond store fails
    {3'd5, 32'h700, 2'd2, 1'b0},  // R10 agent store
    {3'd2, 32'h700, 2'd3, 1'b0},  // R10 lost
    {3'd3, 32'h800, 2'd1, 1'b0},  // R7
    {3'd3, 32'h804, 2'd3, 1'b0},  // R7 word mismatch
    {3'd3, 32'h800, 2'd1, 1'b0},  // R11
    {3'd0, 32'h800, 2'd0, 1'b0},  // R11 read
    {3'd3, 32'h800, 2'd3, 1'b1},  // R11 kept
    {3'd3, 32'h800, 2'd3, 1'b0}   // R4
  };
  localparam int REQ [NV] = '{1,2,7,4,3,3,3,5,5,5,6,6,6,6,6,6,9,9,9,9,9,9,9,
                              10,10,10,10,10,7,7,11,11,11,4};

  logic          clk = 1'b0;
  logic          rst;
  logic          snp_valid;
  logic [IW-1:0] snp_master;
  logic [AW-1:0] snp_addr;
  logic [1:0]    snp_op;
  logic          sc_pass, sc_inhibit;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  resv_monitor #(.NUM_MASTERS(NM), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .snp_valid(snp_valid), .snp_master(snp_master),
    .snp_addr(snp_addr), .snp_op(snp_op), .sc_pass(sc_pass), .sc_inhibit(sc_inhibit)
  );

  // Drives one cycle at the falling edge, checks the same-cycle verdict, commits at the rising edge.
  task automatic step(input logic v, input logic [IW-1:0] m, input logic [AW-1:0] a,
                      input logic [1:0] op, input logic exp_pass, input int req);
    logic exp_inh;
    @(negedge clk);
    snp_valid = v; snp_master = m; snp_addr = a; snp_op = op;
    #1;
    exp_inh = v && (op == 2'd3) && !exp_pass;
    n_chk++;
    if (sc_pass !== exp_pass || sc_inhibit !== exp_inh) begin
      n_bad++;
      $display("FAIL R%0d: pass/inhibit actual %b%b expected %b%b (m=%0d a=%h op=%0d)",
               req, sc_pass, sc_inhibit, exp_pass, exp_inh, m, a, op);
    end
  endtask

  initial begin
    rst = 1'b1; snp_valid = 1'b0; snp_master = '0; snp_addr = '0; snp_op = '0;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (sc_pass !== 1'b0 || sc_inhibit !== 1'b0) begin
      n_bad++;
      $display("FAIL R8: idle outputs actual %b%b expected 00", sc_pass, sc_inhibit);
    end
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++)
      step(1'b1, VEC[i][37:35], VEC[i][34:3], VEC[i][2:1], VEC[i][0], REQ[i]);

    // R11: invalid cycle carrying a store to a reserved word changes nothing
    step(1'b1, 3'd1, 32'h900, 2'd1, 1'b0, 11);
    step(1'b0, 3'd0, 32'h900, 2'd2, 1'b0, 11);
    step(1'b0, 3'd1, 32'h900, 2'd3, 1'b0, 8);   // R8: no verdict without valid
    step(1'b1, 3'd1, 32'h900, 2'd3, 1'b1, 11);

    // R1: reset in the middle of a held reservation
    step(1'b1, 3'd0, 32'hA00, 2'd1, 1'b0, 1);
    @(negedge clk); rst = 1'b1; snp_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    step(1'b1, 3'd0, 32'hA00, 2'd3, 1'b0, 1);

    // R9: all four masters share one word, a pass by master 3 clears the rest
    for (int m = 0; m < NM; m++) step(1'b1, IW'(m), 32'hB00, 2'd1, 1'b0, 9);
    step(1'b1, 3'd3, 32'hB00, 2'd3, 1'b1, 9);
    for (int m = 0; m < NM; m++) step(1'b1, IW'(m), 32'hB00, 2'd3, 1'b0, 9);

    @(negedge clk); snp_valid = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule